// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a 36-bit physical address. It reads a page table of up to three levels from memory, one 32-bit word per level, through a simple request/acknowledge memory port. The walk starts at a root table whose base comes from a register input. At each level the walker decodes the two-bit type field of the word it fetched. A descriptor points to the next table. A leaf ends the walk. That leaf can be at level 1, mapping a 16 MB region, at level 2, mapping 256 KB, or at level 3, mapping a 4 KB page.

On a leaf, the walker checks the requested access (read, write or execute) against a 3-bit rights code, in user or supervisor mode. It then sets the referenced flag, and on a write the modified flag, by writing the updated leaf back to the same address. It returns either the physical address or a fault code together with the level where the fault arose. The walker handles one request at a time: it is busy from acceptance until a one-cycle done pulse.

Top module: `ptw_walker`

## Requirements
- R1: The virtual address splits into a level-1 index in bits 31:24, a level-2 index in bits 23:18, a level-3 index in bits 17:12 and a byte offset in bits 11:0. The level-1 word is read at `{root_ptp, 6'b0} + 4*index1`. Each later level is read at its table base plus 4 times that level's index.
- R2: Bits 1:0 of a fetched word give its type: 0 invalid, 1 descriptor, 2 leaf, 3 reserved. A descriptor's bits 31:2 become physical address bits 35:6 of the next table base.
- R3: An invalid word ends the walk with fault code 1. A reserved word ends it with fault code 2. A descriptor found at level 3 also gives fault code 2.
- R4: A leaf at level 3 yields `{leaf[31:8], va[11:0]}`.
- R5: A leaf at level 2 yields `{leaf[31:14], va[17:0]}`. A leaf at level 1 yields `{leaf[31:20], va[23:0]}`.
- R6: Access kind is encoded 0 read, 1 write, 2 execute, 3 reserved (always denied). `req_super`=1 selects supervisor mode. The leaf rights code is in bits 4:2 and gives user/supervisor rights as follows: 0 r/r, 1 rw/rw, 2 rx/rx, 3 rwx/rwx, 4 x/x, 5 r/rw, 6 none/rx, 7 none/rwx. A denied access gives fault code 3.
- R7: When access is allowed, the leaf is written back to its own address with bit 5 (referenced) set, and bit 6 (modified) also set on a write. This happens only if the word changes. A fault never writes.
- R8: `resp_level` gives the level (1 to 3) of a fault, and is 0 with `resp_fault`=0 on success. `resp_paddr` is 0 after a fault.
- R9: `busy` is high from the cycle after acceptance until the cycle after the one-cycle `done` pulse. `req_valid` is ignored while busy. `mem_req` holds, with a stable address, until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| root_ptp | input | 30 | Root table base, physical address bits 35:6 |
| req_valid | input | 1 | Start a translation (taken when idle) |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| req_super | input | 1 | 1 = supervisor mode |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result pulse |
| resp_paddr | output | 36 | Physical address, valid with done |
| resp_fault | output | 2 | 0 ok, 1 invalid, 2 reserved type, 3 protection |
| resp_level | output | 2 | Level of the fault, 0 on success |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write-back of a leaf |
| mem_addr | output | 36 | Byte address of the entry |
| mem_wdata | output | 32 | Updated leaf word |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Fetched table word |

## Verification
The main sweep runs level-3 leaves through every combination of rights code, privilege mode, access kind and initial referenced/modified state. This separates the permission table and write-back decisions, including the cases where an allowed access must leave memory untouched.

Directed walks then end at level 1 and at level 2, to show that the right number of index bits pass through. Invalid and reserved words are placed at each level, and a descriptor is placed at level 3, to show that the fault code and the level are both reported. A non-zero root base, together with a logged read-address trace, confirms the address arithmetic. A request held high during a walk shows that new requests are ignored while busy.

// File: rtl/ptw_pkg.sv
// Shared constants and types for the page table walker.
// Assumes 32-bit table words and a 36-bit physical address.
package ptw_pkg;
    localparam int ENT_W     = 32;
    localparam int OFF_W     = 12;
    localparam int PPN_W     = 24;
    localparam int PA_W      = PPN_W + OFF_W;
    localparam int PTP_W     = ENT_W - 2;
    localparam int TBL_ALIGN = PA_W - PTP_W;
    localparam int BIT_REF   = 5;
    localparam int BIT_MOD   = 6;

    typedef enum logic [1:0] {ET_NONE = 2'd0, ET_TABLE = 2'd1, ET_LEAF = 2'd2, ET_BAD = 2'd3} etype_e;
    typedef enum logic [1:0] {ACC_RD = 2'd0, ACC_WR = 2'd1, ACC_EX = 2'd2, ACC_RSV = 2'd3} kind_e;
    typedef enum logic [1:0] {FLT_OK = 2'd0, FLT_INVALID = 2'd1, FLT_BADTYPE = 2'd2, FLT_PROT = 2'd3} fault_e;
endpackage

// File: rtl/ptw_perm.sv
// Access rights decoder: maps a 3-bit rights code, privilege mode and
// access kind to allow/deny. Purely combinational.
module ptw_perm
    import ptw_pkg::*;
(
    input  logic [2:0] acc_code,
    input  logic       super_mode,
    input  logic [1:0] kind,
    output logic       allow
);
    logic can_rd, can_wr, can_ex;

    // Rights per code; codes 5..7 differ between user and supervisor.
    always_comb begin
        can_rd = 1'b0;
        can_wr = 1'b0;
        can_ex = 1'b0;
        case (acc_code)
            3'd0: can_rd = 1'b1;
            3'd1: begin can_rd = 1'b1; can_wr = 1'b1; end
            3'd2: begin can_rd = 1'b1; can_ex = 1'b1; end
            3'd3: begin can_rd = 1'b1; can_wr = 1'b1; can_ex = 1'b1; end
            3'd4: can_ex = 1'b1;
            3'd5: begin can_rd = 1'b1; can_wr = super_mode; end
            3'd6: begin can_rd = super_mode; can_ex = super_mode; end
            default: begin can_rd = super_mode; can_wr = super_mode; can_ex = super_mode; end
        endcase
    end

    // Select the right matching the requested kind.
    always_comb begin
        case (kind_e'(kind))
            ACC_RD:  allow = can_rd;
            ACC_WR:  allow = can_wr;
            ACC_EX:  allow = can_ex;
            default: allow = 1'b0;
        endcase
    end

    // Guard the user-denied codes and the reserved kind.
    always_comb begin
        if (!super_mode && acc_code[2:1] == 2'b11)
            p_user_denied_r6: assert (!allow);
        if (kind == 2'd3)
            p_rsv_kind_r6: assert (!allow);
    end
endmodule

// File: rtl/ptw_entry_addr.sv
// Entry address generator: table base plus four times the index of the
// current level. Assumes level is 1..3; other values select level 3.
module ptw_entry_addr
    import ptw_pkg::*;
#(
    parameter int L1_W = 8,
    parameter int L2_W = 6,
    parameter int L3_W = 6
) (
    input  logic [PA_W-1:0]             base,
    input  logic [L1_W+L2_W+L3_W-1:0]   vpn,
    input  logic [1:0]                  level,
    output logic [PA_W-1:0]             addr
);
    localparam int VPN_W = L1_W + L2_W + L3_W;
    logic [PA_W-1:0] idx_bytes;

    // Pick the index field for this level and scale it to bytes.
    always_comb begin
        case (level)
            2'd1:    idx_bytes = PA_W'(vpn[VPN_W-1 -: L1_W]) << 2;
            2'd2:    idx_bytes = PA_W'(vpn[L3_W +: L2_W]) << 2;
            default: idx_bytes = PA_W'(vpn[L3_W-1:0]) << 2;
        endcase
        addr = base + idx_bytes;
    end
endmodule

// File: rtl/ptw_leaf_pa.sv
// Leaf address former: page number on top, with the virtual bits below
// the leaf's level passed straight through.
module ptw_leaf_pa
    import ptw_pkg::*;
#(
    parameter int L1_W = 8,
    parameter int L2_W = 6,
    parameter int L3_W = 6
) (
    input  logic [PPN_W-1:0]               ppn,
    input  logic [L1_W+L2_W+L3_W+OFF_W-1:0] vaddr,
    input  logic [1:0]                     level,
    output logic [PA_W-1:0]                paddr
);
    logic [PA_W-1:0] keep [1:3];
    logic [PA_W-1:0] sel;

    // One pass-through mask per level.
    for (genvar l = 1; l <= 3; l++) begin : g_mask
        localparam int LOW = OFF_W + ((l <= 2) ? L3_W : 0) + ((l == 1) ? L2_W : 0);
        assign keep[l] = (PA_W'(1) << LOW) - PA_W'(1);
    end

    // Merge page number and virtual low bits.
    always_comb begin
        case (level)
            2'd1:    sel = keep[1];
            2'd2:    sel = keep[2];
            default: sel = keep[3];
        endcase
        paddr = ({ppn, {OFF_W{1'b0}}} & ~sel) | (PA_W'(vaddr) & sel);
    end
endmodule

// File: rtl/ptw_walker.sv
// Three-level page table walker. Accepts one translation at a time, reads
// one word per level, checks rights on the leaf, writes back the
// referenced/modified flags when they change, and pulses done.
// Assumes the memory holds mem_req until it answers with mem_ack.
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int L1_W = 8,
    parameter int L2_W = 6,
    parameter int L3_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PTP_W-1:0]  root_ptp,
    input  logic              req_valid,
    input  logic [L1_W+L2_W+L3_W+OFF_W-1:0] req_vaddr,
    input  logic [1:0]        req_kind,
    input  logic              req_super,
    output logic              busy,
    output logic              done,
    output logic [PA_W-1:0]   resp_paddr,
    output logic [1:0]        resp_fault,
    output logic [1:0]        resp_level,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PA_W-1:0]   mem_addr,
    output logic [ENT_W-1:0]  mem_wdata,
    input  logic              mem_ack,
    input  logic [ENT_W-1:0]  mem_rdata
);
    localparam int VA_W = L1_W + L2_W + L3_W + OFF_W;

    typedef enum logic [1:0] {S_IDLE, S_FETCH, S_UPDATE, S_DONE} state_e;

    state_e           state;
    logic [1:0]       level;
    logic [PA_W-1:0]  base;
    logic [VA_W-1:0]  va_q;
    logic             sup_q;
    logic [1:0]       kind_q;
    logic [ENT_W-1:0] ent_q;
    logic [PA_W-1:0]  pa_q;
    fault_e           flt_q;
    logic [1:0]       flvl_q;

    logic             allow;
    logic [PA_W-1:0]  leaf_pa;
    logic [ENT_W-1:0] upd;

    ptw_entry_addr #(.L1_W(L1_W), .L2_W(L2_W), .L3_W(L3_W)) u_addr (
        .base  (base),
        .vpn   (va_q[VA_W-1:OFF_W]),
        .level (level),
        .addr  (mem_addr)
    );

    ptw_perm u_perm (
        .acc_code   (mem_rdata[4:2]),
        .super_mode (sup_q),
        .kind       (kind_q),
        .allow      (allow)
    );

    ptw_leaf_pa #(.L1_W(L1_W), .L2_W(L2_W), .L3_W(L3_W)) u_pa (
        .ppn   (mem_rdata[ENT_W-1 -: PPN_W]),
        .vaddr (va_q),
        .level (level),
        .paddr (leaf_pa)
    );

    // Leaf word with the flags this access must leave set.
    always_comb begin
        upd = mem_rdata | (ENT_W'(1) << BIT_REF);
        if (kind_e'(kind_q) == ACC_WR)
            upd = upd | (ENT_W'(1) << BIT_MOD);
    end

    // Walk sequencer: accept, fetch per level, decode, update, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            level  <= 2'd0;
            base   <= '0;
            va_q   <= '0;
            sup_q  <= 1'b0;
            kind_q <= 2'd0;
            ent_q  <= '0;
            pa_q   <= '0;
            flt_q  <= FLT_OK;
            flvl_q <= 2'd0;
        end else begin
            case (state)
                S_IDLE: if (req_valid) begin
                    base   <= {root_ptp, {TBL_ALIGN{1'b0}}};
                    level  <= 2'd1;
                    va_q   <= req_vaddr;
                    sup_q  <= req_super;
                    kind_q <= req_kind;
                    pa_q   <= '0;
                    flt_q  <= FLT_OK;
                    flvl_q <= 2'd0;
                    state  <= S_FETCH;
                end
                S_FETCH: if (mem_ack) begin
                    case (etype_e'(mem_rdata[1:0]))
                        ET_TABLE: begin
                            if (level == 2'd3) begin
                                flt_q  <= FLT_BADTYPE;
                                flvl_q <= level;
                                state  <= S_DONE;
                            end else begin
                                base  <= {mem_rdata[ENT_W-1:2], {TBL_ALIGN{1'b0}}};
                                level <= level + 2'd1;
                            end
                        end
                        ET_LEAF: begin
                            if (!allow) begin
                                flt_q  <= FLT_PROT;
                                flvl_q <= level;
                                state  <= S_DONE;
                            end else begin
                                pa_q <= leaf_pa;
                                if (upd != mem_rdata) begin
                                    ent_q <= upd;
                                    state <= S_UPDATE;
                                end else begin
                                    state <= S_DONE;
                                end
                            end
                        end
                        ET_NONE: begin
                            flt_q  <= FLT_INVALID;
                            flvl_q <= level;
                            state  <= S_DONE;
                        end
                        default: begin
                            flt_q  <= FLT_BADTYPE;
                            flvl_q <= level;
                            state  <= S_DONE;
                        end
                    endcase
                end
                S_UPDATE: if (mem_ack) state <= S_DONE;
                default:  state <= S_IDLE;
            endcase
        end
    end

    // Port outputs from the sequencer state and result registers.
    always_comb begin
        busy       = (state != S_IDLE);
        done       = (state == S_DONE);
        mem_req    = (state == S_FETCH) || (state == S_UPDATE);
        mem_we     = (state == S_UPDATE);
        mem_wdata  = ent_q;
        resp_paddr = pa_q;
        resp_fault = flt_q;
        resp_level = flvl_q;
    end

    p_hold_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    p_fault_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((resp_fault != 2'd0) == (resp_level != 2'd0)));

    p_wb_success_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_ack |=> done && resp_fault == 2'd0);

    p_wb_refbit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_wdata[BIT_REF] && mem_wdata[1:0] == 2'd2);
endmodule

// File: tb/test_ptw_walker.sv
`timescale 1ns/1ps
module test_ptw_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [29:0] root_ptp = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_super = 1'b0;
    logic        busy, done, mem_req, mem_we;
    logic [35:0] resp_paddr, mem_addr;
    logic [1:0]  resp_fault, resp_level;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int vectors = 0;
    int errors  = 0;
    int wr_cnt  = 0;
    int rd_cnt  = 0;
    logic [35:0] rd_log [0:3];
    logic [31:0] mem [0:4095];

    ptw_walker i_ptw_walker (
        .clk(clk), .rst_n(rst_n), .root_ptp(root_ptp), .req_valid(req_valid),
        .req_vaddr(req_vaddr), .req_kind(req_kind), .req_super(req_super),
        .busy(busy), .done(done), .resp_paddr(resp_paddr), .resp_fault(resp_fault),
        .resp_level(resp_level), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    always #4 clk = ~clk;

    // Memory model: answers one cycle after a request is seen.
    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                mem[mem_addr[13:2]] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rdata <= mem[mem_addr[13:2]];
                if (rd_cnt < 4) rd_log[rd_cnt] <= mem_addr;
                rd_cnt <= rd_cnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ptd(input logic [35:0] base);
        return {base[35:6], 2'b01};
    endfunction

    function automatic logic [31:0] leaf(input logic [23:0] ppn, input logic [2:0] acc, input logic r, input logic m);
        return {ppn, 1'b1, m, r, acc, 2'b10};
    endfunction

    function automatic bit rights_ok(input logic [2:0] c, input logic s, input logic [1:0] k);
        logic [7:0] rd, wr, ex;
        rd = s ? 8'b1110_1111 : 8'b0010_1111;
        wr = s ? 8'b1010_1010 : 8'b0000_1010;
        ex = s ? 8'b1101_1100 : 8'b0001_1100;
        case (k)
            2'd0: return rd[c];
            2'd1: return wr[c];
            2'd2: return ex[c];
            default: return 1'b0;
        endcase
    endfunction

    // One translation; result sampled at the negedge where done is high.
    task automatic walk(input logic [31:0] va, input logic [1:0] k, input logic s,
                        output logic [35:0] pa, output logic [1:0] fc, output logic [1:0] fl);
        int guard;
        @(negedge clk);
        req_vaddr = va; req_kind = k; req_super = s; req_valid = 1'b1;
        rd_cnt = 0;
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (!done && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        chk(done, "R9 done seen", 64'(done), 64'd1);
        pa = resp_paddr; fc = resp_fault; fl = resp_level;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [35:0] pa;
        logic [1:0]  fc, fl;
        logic [31:0] va, ent, nw;
        logic [23:0] ppn;
        int w0;
        for (int i = 0; i < 4096; i++) mem[i] = 32'd0;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(!busy && !done && !mem_req, "R9 reset idle", {61'd0, busy, done, mem_req}, 64'd0);
        rst_n = 1'b1;

        // R4 R6 R7: full rights sweep on level-3 leaves
        for (int n = 0; n < 256; n++) begin
            logic [2:0] acc; logic s; logic [1:0] k; logic r, m; bit ok;
            acc = n[2:0]; s = n[3]; k = n[5:4]; r = n[6]; m = n[7];
            va  = {8'(n * 7 + 3), 6'(n * 5), 6'(n * 3 + 1), 12'(n * 37)};
            ppn = 24'h5A0000 ^ 24'(n * 4951);
            ent = leaf(ppn, acc, r, m);
            mem[10'(va[31:24])]          = ptd(36'h1000);
            mem[12'h400 + 12'(va[23:18])] = ptd(36'h2000);
            mem[12'h800 + 12'(va[17:12])] = ent;
            root_ptp = '0;
            w0 = wr_cnt;
            walk(va, k, s, pa, fc, fl);
            ok = rights_ok(acc, s, k);
            if (!ok) begin
                chk(fc == 2'd3 && fl == 2'd3, "R6 protection fault", {60'd0, fc, fl}, 64'hF);
                chk(pa == 36'd0, "R8 zero paddr on fault", 64'(pa), 64'd0);
                chk(wr_cnt == w0 && mem[12'h800 + 12'(va[17:12])] == ent, "R7 no write on fault",
                    64'(mem[12'h800 + 12'(va[17:12])]), 64'(ent));
            end else begin
                chk(fc == 2'd0 && fl == 2'd0, "R6 allowed", {60'd0, fc, fl}, 64'd0);
                chk(pa == {ppn, va[11:0]}, "R4 level-3 paddr", 64'(pa), 64'({ppn, va[11:0]}));
                nw = ent | 32'h20 | ((k == 2'd1) ? 32'h40 : 32'h0);
                chk(wr_cnt == w0 + ((nw != ent) ? 1 : 0), "R7 write count",
                    64'(wr_cnt - w0), 64'((nw != ent) ? 1 : 0));
                chk(mem[12'h800 + 12'(va[17:12])] == nw, "R7 written word",
                    64'(mem[12'h800 + 12'(va[17:12])]), 64'(nw));
            end
            if (n < 4) begin
                // R1 R2: read address trace
                chk(rd_log[0] == 36'(va[31:24]) * 4, "R1 level-1 address", 64'(rd_log[0]), 64'(36'(va[31:24]) * 4));
                chk(rd_log[1] == 36'h1000 + 36'(va[23:18]) * 4, "R2 level-2 address",
                    64'(rd_log[1]), 64'(36'h1000 + 36'(va[23:18]) * 4));
                chk(rd_log[2] == 36'h2000 + 36'(va[17:12]) * 4, "R2 level-3 address",
                    64'(rd_log[2]), 64'(36'h2000 + 36'(va[17:12]) * 4));
            end
        end

        // R5: leaf at level 1 (no write-back needed, flags already set)
        for (int n = 0; n < 4; n++) begin
            va  = 32'h12345678 + 32'(n * 32'h01031111);
            ppn = 24'hABC123 + 24'(n * 24'h101001);
            mem[10'(va[31:24])] = leaf(ppn, 3'd3, 1'b1, 1'b1);
            w0 = wr_cnt;
            walk(va, 2'd1, 1'b0, pa, fc, fl);
            chk(fc == 2'd0 && pa == {ppn[23:12], va[23:0]}, "R5 level-1 leaf", 64'(pa), 64'({ppn[23:12], va[23:0]}));
            chk(rd_cnt == 1 && wr_cnt == w0, "R5 single read", 64'(rd_cnt), 64'd1);
        end

        // R5 R7: leaf at level 2, write sets both flags
        for (int n = 0; n < 4; n++) begin
            va  = 32'h9ABCDEF0 ^ 32'(n * 32'h00457321);
            ppn = 24'h3C5A96 + 24'(n * 24'h000777);
            ent = leaf(ppn, 3'd1, 1'b0, 1'b0);
            mem[10'(va[31:24])] = ptd(36'h1000);
            mem[12'h400 + 12'(va[23:18])] = ent;
            walk(va, 2'd1, 1'b0, pa, fc, fl);
            chk(fc == 2'd0 && pa == {ppn[23:6], va[17:0]}, "R5 level-2 leaf", 64'(pa), 64'({ppn[23:6], va[17:0]}));
            chk(mem[12'h400 + 12'(va[23:18])] == (ent | 32'h60), "R7 level-2 write-back",
                64'(mem[12'h400 + 12'(va[23:18])]), 64'(ent | 32'h60));
        end

        // R3 R8: invalid and reserved words at each level, descriptor at level 3
        for (int lv = 1; lv <= 3; lv++) begin
            for (int t = 0; t < 3; t++) begin
                logic [31:0] bad;
                logic [1:0] efc;
                bad = (t == 0) ? 32'h0000_0F00 : (t == 1) ? 32'h0000_0F03 : ptd(36'h3000);
                efc = (t == 0) ? 2'd1 : 2'd2;
                if (t == 2 && lv != 3) continue;
                va = 32'h4C8A5123 + 32'(lv * 32'h01041000);
                mem[10'(va[31:24])]          = (lv == 1) ? bad : ptd(36'h1000);
                mem[12'h400 + 12'(va[23:18])] = (lv == 2) ? bad : ptd(36'h2000);
                mem[12'h800 + 12'(va[17:12])] = bad;
                w0 = wr_cnt;
                walk(va, 2'd0, 1'b1, pa, fc, fl);
                chk(fc == efc, "R3 fault code", 64'(fc), 64'(efc));
                chk(fl == 2'(lv), "R8 fault level", 64'(fl), 64'(lv));
                chk(pa == 36'd0 && wr_cnt == w0, "R8 fault paddr zero", 64'(pa), 64'd0);
            end
        end

        // R1: non-zero root base
        root_ptp = 30'h20;
        va = 32'h07ABC123;
        ppn = 24'h777777;
        mem[12'h200 + 12'(va[31:24])] = ptd(36'h1000);
        mem[12'h400 + 12'(va[23:18])] = ptd(36'h2000);
        mem[12'h800 + 12'(va[17:12])] = leaf(ppn, 3'd0, 1'b1, 1'b0);
        walk(va, 2'd0, 1'b0, pa, fc, fl);
        chk(rd_log[0] == 36'h800 + 36'(va[31:24]) * 4, "R1 root base address",
            64'(rd_log[0]), 64'(36'h800 + 36'(va[31:24]) * 4));
        chk(fc == 2'd0 && pa == {ppn, va[11:0]}, "R1 root walk result", 64'(pa), 64'({ppn, va[11:0]}));

        // R9: requests while busy are ignored
        @(negedge clk);
        req_vaddr = va; req_kind = 2'd0; req_super = 1'b0; req_valid = 1'b1;
        rd_cnt = 0;
        @(negedge clk);
        chk(busy, "R9 busy after accept", 64'(busy), 64'd1);
        req_vaddr = 32'hFFFF_FFFF;
        w0 = 0;
        while (!done && w0 < 100) begin @(negedge clk); w0++; end
        req_valid = 1'b0;
        chk(resp_fault == 2'd0 && resp_paddr == {ppn, va[11:0]}, "R9 first request kept",
            64'(resp_paddr), 64'({ppn, va[11:0]}));
        @(negedge clk);
        chk(!busy && !done, "R9 idle after done", {62'd0, busy, done}, 64'd0);
        chk(rd_cnt == 3, "R9 no extra walk", 64'(rd_cnt), 64'd3);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule